// File: doc/BRIEF.md
# Low-Power Sleep and Wake Sequencer

This block controls the low-power state of a converter that is configured over a serial port. It watches writes to a 3-bit operating-mode field. The code 3'b110 puts the device to sleep. While asleep, the analog and digital power-down enables are asserted and the serial interface is turned off.

How serial access comes back depends on how the device is wired:
- When chip-select is in use, pulling it low restores access.
- When chip-select is tied low and the device is the clock master, access returns on a falling edge of the serial data line. The line must first have been high for a qualifying number of clocks.
- When chip-select is tied low and the device is a slave, a received instruction restores access.

Once access is back, writing any non-sleep code starts a fixed power-up interval. One settling conversion follows. The new mode becomes effective only after that conversion. The data-ready indication stays blocked until the conversion after the settling one has also completed. The block does not drive the bias generator or the reference enables. These stay under the control of their own command bits.

Top module: `slp_ctrl`

## Requirements
- R1: An accepted write of mode code 3'b110 makes `analog_pd` and `digital_pd` 1, `ser_en` 0 and `eff_mode` 3'b110 in the cycle after the write.
- R2: While asleep with `ser_en` at 0, `mode_wr` strobes are ignored: the outputs keep their sleep values.
- R3: With `cs_used` at 1, `cs_n` sampled low while asleep sets `ser_en` to 1 in the following cycle.
- R4: With `cs_used` at 0 and `master_sel` at 1, `ser_en` rises after `sdio_in` is sampled low following at least 2 consecutive clock edges at which it was sampled high. A high time of 1 edge before the fall leaves `ser_en` at 0.
- R5: With `cs_used` at 0 and `master_sel` at 0, only an `instr_rx` pulse sets `ser_en`. Edges on `sdio_in` and a low `cs_n` leave it at 0.
- R6: An accepted non-sleep write while asleep releases both power-down enables in the next cycle. A 16-cycle power-up follows, during which `conv_done` is ignored. The written code appears on `eff_mode` in the cycle after the next `conv_done`. Until then `eff_mode` stays 3'b110.
- R7: `drdy_block` is 1 throughout sleep, power-up and the settling conversion. It stays 1 until `conv_done` arrives once more after the new mode took effect, and falls in the cycle after that pulse.
- R8: After reset, `eff_mode` is 3'b000, both power-down enables are 0, `ser_en` is 1 and `drdy_block` is 0. While running, a non-sleep write updates `eff_mode` in the next cycle and leaves `drdy_block` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_used | input | 1 | 1 when chip-select is wired, 0 when tied low |
| master_sel | input | 1 | 1 when the serial port is clock master |
| cs_n | input | 1 | Chip-select, active low |
| sdio_in | input | 1 | Serial data line level |
| instr_rx | input | 1 | Pulse: instruction received by the shifter |
| mode_wr | input | 1 | Pulse: write of the operating-mode field |
| mode_val | input | 3 | Mode code being written |
| conv_done | input | 1 | Pulse: a conversion cycle ended |
| analog_pd | output | 1 | Analog power-down enable |
| digital_pd | output | 1 | Digital core power-down enable |
| ser_en | output | 1 | Serial interface enable |
| eff_mode | output | 3 | Mode currently in effect |
| drdy_block | output | 1 | Forces data-ready inactive when 1 |

## Verification
The end of the power-up count and a conversion-done pulse can land in the same cycle. The pulse must not count as the settling conversion, because the count expires on that very edge. The bench raises `conv_done` exactly at the edge where the sixteenth power-up cycle ends. It then expects `eff_mode` to remain 3'b110 and requires a further pulse before the new code appears. A second overlap comes from a data-line fall that is too short. The bench makes the fall coincide with the first possible qualification point and expects the serial interface to stay off.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_SLEEP  = 2'd1,
      ST_PWRUP  = 2'd2,
      ST_SETTLE = 2'd3
   } slp_state_t;
endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
   parameter int HIGH_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_used,
   input  logic master_sel,
   input  logic cs_n,
   input  logic sdio_in,
   input  logic instr_rx,
   output logic wake_hit
);
   logic qual_fall;

   generate
      if (HIGH_MIN == 0) begin : g_any_fall
         logic sd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sd_q <= 1'b0;
            else        sd_q <= sdio_in;
         end
         assign qual_fall = sd_q & ~sdio_in;
      end else begin : g_timed_fall
         localparam int HI_W = $clog2(HIGH_MIN + 1);
         localparam logic [HI_W-1:0] HI_SAT = HI_W'(HIGH_MIN);
         logic [HI_W-1:0] hi_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          hi_cnt <= '0;
            else if (!sdio_in)                   hi_cnt <= '0;
            else if (hi_cnt != HI_SAT)           hi_cnt <= hi_cnt + 1'b1;
         end
         assign qual_fall = ~sdio_in & (hi_cnt >= HI_SAT);
      end
   endgenerate

   always_comb begin
      if (cs_used)         wake_hit = ~cs_n;
      else if (master_sel) wake_hit = qual_fall;
      else                 wake_hit = instr_rx;
   end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
   import slp_pkg::*;
#(
   parameter int              MODE_W     = 3,
   parameter int              PWRUP_CYC  = 16,
   parameter logic [MODE_W-1:0] SLEEP_CODE = 3'b110,
   parameter logic [MODE_W-1:0] RST_MODE   = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_val,
   input  logic              wake_hit,
   input  logic              conv_done,
   output slp_state_t        state,
   output logic              ser_en,
   output logic [MODE_W-1:0] eff_mode,
   output logic              settle_done
);
   localparam int CNT_W = $clog2(PWRUP_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYC - 1);

   logic [CNT_W-1:0]  pu_cnt;
   logic [MODE_W-1:0] pend_mode;
   logic              wr_sleep;

   assign wr_sleep    = mode_wr & (mode_val == SLEEP_CODE);
   assign settle_done = (state == ST_SETTLE) & conv_done & ~mode_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         ser_en    <= 1'b1;
         eff_mode  <= RST_MODE;
         pend_mode <= RST_MODE;
         pu_cnt    <= '0;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (mode_wr) eff_mode <= mode_val;
               if (wr_sleep) begin
                  state  <= ST_SLEEP;
                  ser_en <= 1'b0;
               end
            end
            ST_SLEEP: begin
               if (!ser_en) begin
                  if (wake_hit) ser_en <= 1'b1;
               end else if (mode_wr && !wr_sleep) begin
                  pend_mode <= mode_val;
                  pu_cnt    <= '0;
                  state     <= ST_PWRUP;
               end
            end
            ST_PWRUP: begin
               if (wr_sleep) begin
                  state  <= ST_SLEEP;
                  ser_en <= 1'b0;
               end else begin
                  if (mode_wr) pend_mode <= mode_val;
                  if (pu_cnt == CNT_LAST) state  <= ST_SETTLE;
                  else                    pu_cnt <= pu_cnt + 1'b1;
               end
            end
            ST_SETTLE: begin
               if (wr_sleep) begin
                  state  <= ST_SLEEP;
                  ser_en <= 1'b0;
               end else if (mode_wr) begin
                  pend_mode <= mode_val;
               end else if (conv_done) begin
                  eff_mode <= pend_mode;
                  state    <= ST_RUN;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/slp_drdy_gate.sv
module slp_drdy_gate
   import slp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  slp_state_t state,
   input  logic       settle_done,
   input  logic       conv_done,
   output logic       drdy_block
);
   logic second_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           second_pend <= 1'b0;
      else if (settle_done)                 second_pend <= 1'b1;
      else if (state != ST_RUN)             second_pend <= 1'b0;
      else if (conv_done)                   second_pend <= 1'b0;
   end

   assign drdy_block = (state != ST_RUN) | second_pend;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
   import slp_pkg::*;
#(
   parameter int                MODE_W     = 3,
   parameter int                PWRUP_CYC  = 16,
   parameter int                HIGH_MIN   = 2,
   parameter logic [MODE_W-1:0] SLEEP_CODE = 3'b110,
   parameter logic [MODE_W-1:0] RST_MODE   = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_used,
   input  logic              master_sel,
   input  logic              cs_n,
   input  logic              sdio_in,
   input  logic              instr_rx,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_val,
   input  logic              conv_done,
   output logic              analog_pd,
   output logic              digital_pd,
   output logic              ser_en,
   output logic [MODE_W-1:0] eff_mode,
   output logic              drdy_block
);
   generate
      if (PWRUP_CYC < 2) begin : g_bad_pwrup
         $error("slp_ctrl: PWRUP_CYC must be at least 2");
      end
      if (HIGH_MIN < 0) begin : g_bad_high
         $error("slp_ctrl: HIGH_MIN must not be negative");
      end
      if (MODE_W < 2) begin : g_bad_width
         $error("slp_ctrl: MODE_W too narrow");
      end
      if (RST_MODE == SLEEP_CODE) begin : g_bad_rst
         $error("slp_ctrl: reset mode must not be the sleep code");
      end
   endgenerate

   slp_state_t state;
   logic       wake_hit;
   logic       settle_done;

   slp_wake_qual #(.HIGH_MIN(HIGH_MIN)) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_used    (cs_used),
      .master_sel (master_sel),
      .cs_n       (cs_n),
      .sdio_in    (sdio_in),
      .instr_rx   (instr_rx),
      .wake_hit   (wake_hit)
   );

   slp_seq #(
      .MODE_W     (MODE_W),
      .PWRUP_CYC  (PWRUP_CYC),
      .SLEEP_CODE (SLEEP_CODE),
      .RST_MODE   (RST_MODE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (mode_wr),
      .mode_val    (mode_val),
      .wake_hit    (wake_hit),
      .conv_done   (conv_done),
      .state       (state),
      .ser_en      (ser_en),
      .eff_mode    (eff_mode),
      .settle_done (settle_done)
   );

   slp_drdy_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .settle_done (settle_done),
      .conv_done   (conv_done),
      .drdy_block  (drdy_block)
   );

   assign analog_pd  = (state == ST_SLEEP);
   assign digital_pd = (state == ST_SLEEP);
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
   parameter int                MODE_W     = 3,
   parameter logic [MODE_W-1:0] SLEEP_CODE = 3'b110
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_used,
   input logic              master_sel,
   input logic              sdio_in,
   input logic              conv_done,
   input logic              analog_pd,
   input logic              ser_en,
   input logic [MODE_W-1:0] eff_mode,
   input logic              drdy_block
);
   // R1: sleep entry turns the serial port off
   p_sleep_ser_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(analog_pd) |-> !ser_en);

   // R1: powered down only with the sleep code in effect
   p_pd_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      analog_pd |-> (eff_mode == SLEEP_CODE));

   // R4: master-role wake follows a sampled low data line
   p_master_wake_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ser_en) && analog_pd && !cs_used && master_sel) |-> !$past(sdio_in));

   // R6: leaving the sleep code requires a conversion end
   p_mode_after_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(eff_mode) == SLEEP_CODE) && (eff_mode != SLEEP_CODE)) |-> $past(conv_done));

   // R7: data-ready stays blocked while powered down
   p_drdy_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      analog_pd |-> drdy_block);

   // R7: block is released only by a conversion end
   p_drdy_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_block) |-> $past(conv_done));
endmodule

bind slp_ctrl slp_ctrl_chk #(.MODE_W(MODE_W), .SLEEP_CODE(SLEEP_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_used    (cs_used),
   .master_sel (master_sel),
   .sdio_in    (sdio_in),
   .conv_done  (conv_done),
   .analog_pd  (analog_pd),
   .ser_en     (ser_en),
   .eff_mode   (eff_mode),
   .drdy_block (drdy_block)
);

// File: tb/slp_ctrl_tb.sv
`timescale 1ns/1ps
module slp_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_used = 1'b1;
   logic       master_sel = 1'b0;
   logic       cs_n = 1'b1;
   logic       sdio_in = 1'b0;
   logic       instr_rx = 1'b0;
   logic       mode_wr = 1'b0;
   logic [2:0] mode_val = 3'b000;
   logic       conv_done = 1'b0;
   logic       analog_pd, digital_pd, ser_en, drdy_block;
   logic [2:0] eff_mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [2:0] mode;
      logic       pd;
      logic       ser;
      logic       blk;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   always #2 clk = ~clk;

   slp_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_used    (cs_used),
      .master_sel (master_sel),
      .cs_n       (cs_n),
      .sdio_in    (sdio_in),
      .instr_rx   (instr_rx),
      .mode_wr    (mode_wr),
      .mode_val   (mode_val),
      .conv_done  (conv_done),
      .analog_pd  (analog_pd),
      .digital_pd (digital_pd),
      .ser_en     (ser_en),
      .eff_mode   (eff_mode),
      .drdy_block (drdy_block)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic expect_out(input logic [2:0] m, input logic pd, input logic ser,
                             input logic blk, input string tag);
      exp_t e;
      e.mode = m; e.pd = pd; e.ser = ser; e.blk = blk; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic write_mode(input logic [2:0] v);
      mode_wr = 1'b1; mode_val = v;
      step();
      mode_wr = 1'b0;
   endtask

   task automatic pulse_conv();
      conv_done = 1'b1;
      step();
      conv_done = 1'b0;
   endtask

   // monitor: pops and compares expected items
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (eff_mode !== e.mode || analog_pd !== e.pd || digital_pd !== e.pd ||
                ser_en !== e.ser || drdy_block !== e.blk) begin
               errors++;
               $display("FAIL %s: actual mode=%b apd=%b dpd=%b ser=%b blk=%b expected mode=%b pd=%b ser=%b blk=%b",
                        e.tag, eff_mode, analog_pd, digital_pd, ser_en, drdy_block,
                        e.mode, e.pd, e.ser, e.blk);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      expect_out(3'b000, 1'b0, 1'b1, 1'b0, "R8 reset");

      // chip-select wired
      write_mode(3'b110);
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R1 sleep entry");
      write_mode(3'b001);
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R2 write ignored");
      cs_n = 1'b0;
      step();
      cs_n = 1'b1;
      expect_out(3'b110, 1'b1, 1'b1, 1'b1, "R3 cs wake");
      write_mode(3'b010);
      expect_out(3'b110, 1'b0, 1'b1, 1'b1, "R6 power released");
      repeat (20) step();
      expect_out(3'b110, 1'b0, 1'b1, 1'b1, "R6 mode held until conversion");
      pulse_conv();
      expect_out(3'b010, 1'b0, 1'b1, 1'b1, "R7 second cycle blocked");
      pulse_conv();
      expect_out(3'b010, 1'b0, 1'b1, 1'b0, "R7 block released");

      // chip-select tied low, master role
      cs_used = 1'b0; master_sel = 1'b1; sdio_in = 1'b0;
      write_mode(3'b110);
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R1 sleep entry master");
      sdio_in = 1'b1;
      step();
      sdio_in = 1'b0;
      step();
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R4 short high ignored");
      step();
      sdio_in = 1'b1;
      step();
      step();
      sdio_in = 1'b0;
      step();
      expect_out(3'b110, 1'b1, 1'b1, 1'b1, "R4 qualified fall");
      write_mode(3'b000);
      expect_out(3'b110, 1'b0, 1'b1, 1'b1, "R6 power released master");
      repeat (15) step();
      conv_done = 1'b1;
      step();
      conv_done = 1'b0;
      expect_out(3'b110, 1'b0, 1'b1, 1'b1, "R6 conversion in power-up ignored");
      pulse_conv();
      expect_out(3'b000, 1'b0, 1'b1, 1'b1, "R6 mode applied after settle");
      pulse_conv();
      expect_out(3'b000, 1'b0, 1'b1, 1'b0, "R7 block released master");

      // chip-select tied low, slave role
      master_sel = 1'b0;
      write_mode(3'b110);
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R1 sleep entry slave");
      sdio_in = 1'b1;
      repeat (4) step();
      sdio_in = 1'b0;
      step();
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R5 data edge ignored");
      cs_n = 1'b0;
      step();
      cs_n = 1'b1;
      expect_out(3'b110, 1'b1, 1'b0, 1'b1, "R5 cs ignored");
      instr_rx = 1'b1;
      step();
      instr_rx = 1'b0;
      expect_out(3'b110, 1'b1, 1'b1, 1'b1, "R5 instruction wake");
      write_mode(3'b011);
      expect_out(3'b110, 1'b0, 1'b1, 1'b1, "R6 power released slave");
      repeat (20) step();
      expect_out(3'b110, 1'b0, 1'b1, 1'b1, "R7 settle blocked");
      pulse_conv();
      expect_out(3'b011, 1'b0, 1'b1, 1'b1, "R6 slave mode applied");
      pulse_conv();
      expect_out(3'b011, 1'b0, 1'b1, 1'b0, "R7 slave release");

      // running mode change
      write_mode(3'b101);
      expect_out(3'b101, 1'b0, 1'b1, 1'b0, "R8 run write");

      step();
      step();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule